// File: doc/BRIEF.md
# Checkpoint and Restore Power Controller

This block is the central mode controller of an intermittently powered processor that runs from harvested energy. It watches the supply status reported by the energy module and moves the system through four modes: off, restore, run and backup. While the core runs, a planned power-down request or a sudden supply-failure warning starts a backup. The backup copies every word of volatile machine state into non-volatile checkpoint storage. Each non-volatile access is held until the storage reports completion, because those accesses take a variable and fairly long time.

When the supply returns and a complete checkpoint exists, the controller reads the checkpoint back into volatile state and resumes the core without a full boot. If the checkpoint is absent or was torn by a supply collapse during the backup, it raises a one-cycle cold-boot request instead. The checkpoint-valid flag is dropped at the start of every backup. It is raised again only after the final word has been committed.

Top module: `ckptPowerCtrl`

## Requirements
- R1: After reset the mode output is OFF (code 0), and coreRun, ckptValid and coldBoot are all low.
- R2: Mode codes are OFF=0, RESTORE=1, RUN=2, BACKUP=3. coreRun is high exactly in the cycles where the mode is RUN.
- R3: In RUN, a high pdReq or supplyWarn at a clock edge makes the mode BACKUP from the next cycle, and ckptValid is low from that same cycle.
- R4: A backup writes state words in ascending address order, 0 to WORDS-1. For each word, nvWr stays high with a stable address until nvDone. The data written to non-volatile word i is volatile word i.
- R5: The cycle after nvDone for the last word of a backup, the mode is OFF and ckptValid is high.
- R6: If supplyGood is low at an edge during BACKUP, the mode becomes OFF and ckptValid stays low, so the torn checkpoint is never restored.
- R7: supplyWarn and pdReq have no effect while a backup is in progress. The backup still completes every word with the correct data.
- R8: The mode leaves OFF only when supplyGood is high after it has been seen low since entering OFF. Reset counts as having seen it low. After a completed backup, a supply that stays high keeps the mode OFF.
- R9: On leaving OFF with ckptValid high, the mode is RESTORE. Non-volatile words are read in ascending order, and each is written into volatile word i in the cycle its nvDone is high. The mode is then RUN, with no coldBoot.
- R10: On leaving OFF with ckptValid low, the mode goes directly to RUN. coldBoot is high for exactly the first RUN cycle, and no non-volatile read is issued.
- R11: nvWr and nvRd are never high together. nvWr is high only in BACKUP, and nvRd only in RESTORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyGood | input | 1 | Supply is adequate for operation |
| supplyWarn | input | 1 | Supply is about to fail |
| pdReq | input | 1 | Planned power-down request |
| volAddr | output | IDX_W | Volatile state word address |
| volRdData | input | DATA_W | Volatile state read data (combinational) |
| volWr | output | 1 | Volatile state write strobe |
| volWrData | output | DATA_W | Volatile state write data |
| nvAddr | output | IDX_W | Checkpoint storage word address |
| nvWr | output | 1 | Checkpoint write request, held until nvDone |
| nvWrData | output | DATA_W | Checkpoint write data |
| nvRd | output | 1 | Checkpoint read request, held until nvDone |
| nvRdData | input | DATA_W | Checkpoint read data, valid with nvDone |
| nvDone | input | 1 | One-cycle completion of the current access |
| mode | output | 2 | Current mode code |
| coreRun | output | 1 | Core clock/run enable |
| ckptValid | output | 1 | A complete checkpoint is held |
| coldBoot | output | 1 | One-cycle request for a full boot |

## Verification
The bench aims at a warning that arrives in the middle of a backup. A design that restarted or aborted the backup there would leave wrong or missing checkpoint words. The bench also collapses the supply partway through a backup. A design that kept the flag set there, or set it early, would later restore a half-written state instead of requesting a cold boot. It also holds the supply high after a completed backup, where a controller that does not wait for the supply to drop would restore immediately. The restore pass scrambles volatile state beforehand, so any skipped, reordered or mistimed write-back shows up as a wrong word.

// File: rtl/ckptPkg.sv
package ckptPkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_RESTORE = 2'd1,
    MODE_RUN     = 2'd2,
    MODE_BACKUP  = 2'd3
  } pwrMode_t;

  // strobes from the sequencer to the copy datapath
  typedef struct packed {
    logic idxClr;
    logic idxInc;
    logic saveActive;
    logic loadActive;
  } dpStrobe_t;

endpackage

// File: rtl/ckptDatapath.sv
module ckptDatapath
  import ckptPkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic              lastWord,
  output logic [IDX_W-1:0]  volAddr,
  input  logic [DATA_W-1:0] volRdData,
  output logic              volWr,
  output logic [DATA_W-1:0] volWrData,
  output logic [IDX_W-1:0]  nvAddr,
  output logic              nvWr,
  output logic [DATA_W-1:0] nvWrData,
  output logic              nvRd,
  input  logic [DATA_W-1:0] nvRdData,
  input  logic              nvDone
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic [IDX_W-1:0] wordIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordIdx <= '0;
    end else if (strobe.idxClr) begin
      wordIdx <= '0;
    end else if (strobe.idxInc) begin
      wordIdx <= wordIdx + 1'b1;
    end
  end

  always_comb begin
    lastWord  = (wordIdx == LAST_IDX);
    volAddr   = wordIdx;
    nvAddr    = wordIdx;
    // backup path: volatile word streams straight into the storage port
    nvWr      = strobe.saveActive;
    nvWrData  = volRdData;
    // restore path: read data lands in volatile state on completion
    nvRd      = strobe.loadActive;
    volWr     = strobe.loadActive & nvDone;
    volWrData = nvRdData;
  end

endmodule

// File: rtl/ckptSequencer.sv
module ckptSequencer
  import ckptPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyGood,
  input  logic      supplyWarn,
  input  logic      pdReq,
  input  logic      nvDone,
  input  logic      lastWord,
  output dpStrobe_t strobe,
  output pwrMode_t  modeQ,
  output logic      coreRun,
  output logic      ckptValid,
  output logic      coldBoot
);

  pwrMode_t modeD;
  logic     seenLowQ, seenLowD;
  logic     validD, coldD;
  logic     wakeUp;

  assign wakeUp = supplyGood & seenLowQ;

  always_comb begin
    modeD    = modeQ;
    seenLowD = seenLowQ;
    validD   = ckptValid;
    coldD    = 1'b0;
    strobe   = '0;
    unique case (modeQ)
      MODE_OFF: begin
        if (!supplyGood) begin
          seenLowD = 1'b1;
        end else if (wakeUp) begin
          seenLowD = 1'b0;
          if (ckptValid) begin
            modeD         = MODE_RESTORE;
            strobe.idxClr = 1'b1;
          end else begin
            modeD = MODE_RUN;
            coldD = 1'b1;
          end
        end
      end
      MODE_RESTORE: begin
        strobe.loadActive = 1'b1;
        if (!supplyGood) begin
          modeD    = MODE_OFF;
          seenLowD = 1'b1;
        end else if (nvDone) begin
          if (lastWord) modeD = MODE_RUN;
          else          strobe.idxInc = 1'b1;
        end
      end
      MODE_RUN: begin
        if (pdReq || supplyWarn) begin
          modeD         = MODE_BACKUP;
          validD        = 1'b0;
          strobe.idxClr = 1'b1;
        end
      end
      MODE_BACKUP: begin
        strobe.saveActive = 1'b1;
        if (!supplyGood) begin
          modeD    = MODE_OFF;
          seenLowD = 1'b1;
        end else if (nvDone) begin
          if (lastWord) begin
            modeD  = MODE_OFF;
            validD = 1'b1;
          end else begin
            strobe.idxInc = 1'b1;
          end
        end
      end
      default: modeD = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_OFF;
      seenLowQ  <= 1'b1;
      ckptValid <= 1'b0;
      coldBoot  <= 1'b0;
    end else begin
      modeQ     <= modeD;
      seenLowQ  <= seenLowD;
      ckptValid <= validD;
      coldBoot  <= coldD;
    end
  end

  assign coreRun = (modeQ == MODE_RUN);

endmodule

// File: rtl/ckptPowerCtrl.sv
module ckptPowerCtrl
  import ckptPkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              supplyWarn,
  input  logic              pdReq,
  output logic [IDX_W-1:0]  volAddr,
  input  logic [DATA_W-1:0] volRdData,
  output logic              volWr,
  output logic [DATA_W-1:0] volWrData,
  output logic [IDX_W-1:0]  nvAddr,
  output logic              nvWr,
  output logic [DATA_W-1:0] nvWrData,
  output logic              nvRd,
  input  logic [DATA_W-1:0] nvRdData,
  input  logic              nvDone,
  output logic [1:0]        mode,
  output logic              coreRun,
  output logic              ckptValid,
  output logic              coldBoot
);

  dpStrobe_t strobe;
  pwrMode_t  modeQ;
  logic      lastWord;

  ckptSequencer u_seq (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .supplyWarn(supplyWarn),
    .pdReq(pdReq), .nvDone(nvDone), .lastWord(lastWord), .strobe(strobe),
    .modeQ(modeQ), .coreRun(coreRun), .ckptValid(ckptValid), .coldBoot(coldBoot)
  );

  ckptDatapath #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lastWord(lastWord),
    .volAddr(volAddr), .volRdData(volRdData), .volWr(volWr), .volWrData(volWrData),
    .nvAddr(nvAddr), .nvWr(nvWr), .nvWrData(nvWrData), .nvRd(nvRd),
    .nvRdData(nvRdData), .nvDone(nvDone)
  );

  assign mode = modeQ;

endmodule

// File: rtl/ckptPowerCtrlChecker.sv
module ckptPowerCtrlChecker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             supplyGood,
  input logic             supplyWarn,
  input logic             pdReq,
  input logic             nvWr,
  input logic             nvRd,
  input logic             nvDone,
  input logic [IDX_W-1:0] nvAddr,
  input logic [1:0]       mode,
  input logic             coreRun,
  input logic             ckptValid,
  input logic             coldBoot
);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(nvWr && nvRd));

  a_r11_write_in_backup: assert property (@(posedge clk) disable iff (!rstN)
    nvWr |-> mode == 2'd3);

  a_r3_enter_backup: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && (pdReq || supplyWarn)) |=> (mode == 2'd3 && !ckptValid));

  a_r7_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && supplyGood && !nvDone) |=> mode == 2'd3);

  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (nvWr && !nvDone && supplyGood) |=> (nvWr && $stable(nvAddr)));

  a_r6_torn_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && !supplyGood) |=> (mode == 2'd0 && !ckptValid));

  a_r5_valid_after_backup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ckptValid) |-> ($past(mode) == 2'd3 && mode == 2'd0));

  a_r10_cold_pulse: assert property (@(posedge clk) disable iff (!rstN)
    coldBoot |=> !coldBoot);

  a_r10_cold_in_run: assert property (@(posedge clk) disable iff (!rstN)
    coldBoot |-> (coreRun && !ckptValid));

endmodule

bind ckptPowerCtrl ckptPowerCtrlChecker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .supplyWarn(supplyWarn),
  .pdReq(pdReq), .nvWr(nvWr), .nvRd(nvRd), .nvDone(nvDone), .nvAddr(nvAddr),
  .mode(mode), .coreRun(coreRun), .ckptValid(ckptValid), .coldBoot(coldBoot)
);

// File: tb/sim_ckptPowerCtrl.sv
module sim_ckptPowerCtrl;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 8;
  localparam int DATA_W     = 16;
  localparam int IDX_W      = 3;
  localparam int NV_LAT     = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              supplyGood = 1'b0;
  logic              supplyWarn = 1'b0;
  logic              pdReq = 1'b0;
  logic [IDX_W-1:0]  volAddr, nvAddr;
  logic [DATA_W-1:0] volRdData, volWrData, nvWrData;
  logic [DATA_W-1:0] nvRdData = '0;
  logic              volWr, nvWr, nvRd;
  logic              nvDone = 1'b0;
  logic [1:0]        mode;
  logic              coreRun, ckptValid, coldBoot;

  logic [DATA_W-1:0] volMem [WORDS];
  logic [DATA_W-1:0] nvMem  [WORDS];
  logic [DATA_W-1:0] golden [WORDS];
  logic              coreWe = 1'b0;
  logic [IDX_W-1:0]  coreAddr = '0;
  logic [DATA_W-1:0] coreData = '0;
  logic              scramble = 1'b0;
  int                latCnt = 0;
  int                saveSeq = 0, loadSeq = 0;
  int                orderErr = 0, readCount = 0;
  int                checkCount = 0, failCount = 0;
  bit                finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckptPowerCtrl #(.WORDS(WORDS), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .supplyWarn(supplyWarn),
    .pdReq(pdReq), .volAddr(volAddr), .volRdData(volRdData), .volWr(volWr),
    .volWrData(volWrData), .nvAddr(nvAddr), .nvWr(nvWr), .nvWrData(nvWrData),
    .nvRd(nvRd), .nvRdData(nvRdData), .nvDone(nvDone), .mode(mode),
    .coreRun(coreRun), .ckptValid(ckptValid), .coldBoot(coldBoot)
  );

  assign volRdData = volMem[volAddr];

  // volatile state model
  always @(posedge clk) begin
    if (scramble) begin
      for (int i = 0; i < WORDS; i++) volMem[i] <= DATA_W'(16'hDEAD ^ i);
    end else if (volWr) begin
      volMem[volAddr] <= volWrData;
    end else if (coreWe) begin
      volMem[coreAddr] <= coreData;
    end
  end

  // non-volatile storage model with fixed latency and a one-cycle done pulse
  always @(negedge clk) begin
    if (nvDone) begin
      nvDone <= 1'b0;
      latCnt <= 0;
    end else if (nvWr || nvRd) begin
      if (latCnt == NV_LAT) begin
        nvDone <= 1'b1;
        if (nvWr) begin
          nvMem[nvAddr] <= nvWrData;
          if (int'(nvAddr) != saveSeq) orderErr <= orderErr + 1;
          saveSeq <= saveSeq + 1;
        end else begin
          nvRdData <= nvMem[nvAddr];
          if (int'(nvAddr) != loadSeq) orderErr <= orderErr + 1;
          loadSeq <= loadSeq + 1;
          readCount <= readCount + 1;
        end
      end else begin
        latCnt <= latCnt + 1;
      end
    end else begin
      latCnt <= 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitMode(input logic [1:0] target);
    for (int k = 0; k < 400; k++) begin
      if (mode == target) break;
      @(negedge clk);
    end
  endtask

  task automatic loadPattern(input logic [DATA_W-1:0] seed);
    for (int i = 0; i < WORDS; i++) begin
      coreWe = 1'b1; coreAddr = IDX_W'(i); coreData = seed + DATA_W'(i * 16'h0111);
      golden[i] = coreData;
      @(negedge clk);
    end
    coreWe = 1'b0;
  endtask

  task automatic testReset();
    tick(2);
    check(mode == 2'd0, "R1 mode after reset", 32'(mode), 0);
    check(!coreRun && !ckptValid && !coldBoot, "R1 outputs after reset",
          {29'd0, coreRun, ckptValid, coldBoot}, 0);
  endtask

  task automatic testColdBoot();
    int r0 = readCount;
    supplyGood = 1'b1;
    tick(1);
    check(mode == 2'd2, "R10 direct to RUN", 32'(mode), 2);
    check(coldBoot == 1'b1, "R10 coldBoot first RUN cycle", 32'(coldBoot), 1);
    check(coreRun == 1'b1, "R2 coreRun in RUN", 32'(coreRun), 1);
    tick(1);
    check(coldBoot == 1'b0, "R10 coldBoot single cycle", 32'(coldBoot), 0);
    check(readCount == r0, "R10 no checkpoint read", 32'(readCount), 32'(r0));
  endtask

  task automatic testPlannedBackup(input bit warnMid);
    int bad = 0;
    saveSeq = 0; orderErr = 0;
    pdReq = 1'b1;
    tick(1);
    pdReq = 1'b0;
    check(mode == 2'd3, "R3 BACKUP after request", 32'(mode), 3);
    check(!ckptValid, "R3 valid cleared at backup start", 32'(ckptValid), 0);
    check(!coreRun, "R2 coreRun low in BACKUP", 32'(coreRun), 0);
    if (warnMid) begin
      tick(9);
      supplyWarn = 1'b1; pdReq = 1'b1;
      tick(2);
      check(mode == 2'd3, "R7 warning ignored in BACKUP", 32'(mode), 3);
      supplyWarn = 1'b0; pdReq = 1'b0;
    end
    waitMode(2'd0);
    check(ckptValid, "R5 valid after complete backup", 32'(ckptValid), 1);
    for (int i = 0; i < WORDS; i++) if (nvMem[i] != golden[i]) bad++;
    check(bad == 0, warnMid ? "R7 checkpoint intact after warning" : "R4 checkpoint contents",
          32'(bad), 0);
    check(saveSeq == WORDS && orderErr == 0, "R4 ascending single write per word",
          32'(saveSeq), 32'(WORDS));
  endtask

  task automatic testHoldOff();
    tick(10);
    check(mode == 2'd0, "R8 stays OFF with supply still high", 32'(mode), 0);
  endtask

  task automatic testRestore();
    int bad = 0;
    int r0 = readCount;
    loadSeq = 0; orderErr = 0;
    supplyGood = 1'b0; scramble = 1'b1;
    tick(3);
    scramble = 1'b0;
    check(mode == 2'd0, "R8 OFF while supply low", 32'(mode), 0);
    supplyGood = 1'b1;
    tick(1);
    check(mode == 2'd1, "R9 RESTORE when valid", 32'(mode), 1);
    waitMode(2'd2);
    tick(1);
    for (int i = 0; i < WORDS; i++) if (volMem[i] != golden[i]) bad++;
    check(bad == 0, "R9 volatile state restored", 32'(bad), 0);
    check(readCount - r0 == WORDS && orderErr == 0, "R9 ascending reads",
          32'(readCount - r0), 32'(WORDS));
    check(!coldBoot, "R9 no coldBoot after restore", 32'(coldBoot), 0);
  endtask

  task automatic testSuddenWarn();
    loadPattern(16'h5A00);
    saveSeq = 0;
    supplyWarn = 1'b1;
    tick(1);
    supplyWarn = 1'b0;
    check(mode == 2'd3, "R3 BACKUP after warning", 32'(mode), 3);
    waitMode(2'd0);
    check(ckptValid, "R5 valid after warned backup", 32'(ckptValid), 1);
  endtask

  task automatic testTorn();
    int r0;
    // come back up from the warned backup
    supplyGood = 1'b0; tick(2); supplyGood = 1'b1;
    waitMode(2'd2);
    tick(1);
    pdReq = 1'b1; tick(1); pdReq = 1'b0;
    tick(7);
    supplyGood = 1'b0;
    tick(1);
    check(mode == 2'd0, "R6 OFF on collapse during backup", 32'(mode), 0);
    check(!ckptValid, "R6 torn checkpoint invalid", 32'(ckptValid), 0);
    r0 = readCount;
    tick(2);
    supplyGood = 1'b1;
    tick(1);
    check(mode == 2'd2 && coldBoot, "R10 cold boot after torn backup",
          {30'd0, mode == 2'd2, coldBoot}, 3);
    check(readCount == r0, "R10 no read after torn backup", 32'(readCount), 32'(r0));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checkCount++; failCount++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin nvMem[i] = '0; golden[i] = '0; end
    tick(3);
    rstN = 1'b1;
    testReset();
    testColdBoot();
    loadPattern(16'h1200);
    testPlannedBackup(1'b0);
    testHoldOff();
    testRestore();
    loadPattern(16'hC300);
    testPlannedBackup(1'b1);
    testRestore();
    testSuddenWarn();
    testTorn();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule